// File: doc/BRIEF.md
# Floppy Disk Controller Command and Status Registers

This block is the host-facing control section of a floppy disk controller that times sectors from holes punched in the disk. It decodes a 1 KB memory-mapped window. The lower half of that window belongs to a boot store that lives outside this block, so reads there return 0xFF. The upper half holds four register locations, which repeat through the whole half. A host write to offset 0 or 1 carries a command. The top three bits of the byte are an opcode and the low five bits are its modifier. The opcodes select a drive and head, control the sector interrupt, step the head one track, arm the write gate and reset the controller.

Host reads return one of three bytes. Offset 0 returns a sector status byte. Offset 1 returns a drive status byte. Offsets 2 and 3 pass through the data byte supplied by the data path.

The block also owns the state behind these registers:
- an idle timer that drops the drive selection when the host stops polling;
- the write-enable latch, which a sector boundary closes;
- the step pulse and the latched step direction;
- a sticky flag for step commands issued faster than the drive allows;
- the sector interrupt flag.

All time spans are parameters counted in clock cycles.

Top module: `flop_ctl_regs`

## Requirements
- R1: A read with `bus_hit` low, or with address bit 9 low (lower half), returns 0xFF. In the upper half only address bits 1:0 pick the register, and offsets 2 and 3 both return `data_byte`.
- R2: Offset 0 reads as {sector flag (bit 7), sector interrupt flag (bit 6), `strap` (bits 5:4), `sector_addr` (bits 3:0)}.
- R3: Offset 1 reads as {`xfer_flag` (bit 7), `host_int_en` (bit 6), `drv_ready` (bit 5), `wprot` (bit 4), `trk0` (bit 3), not-selected (bit 2, 0 when a drive is selected), selected unit (bits 1:0)}. After any general reset the unit field is 0 and bit 2 is 1.
- R4: Opcode 0 (bits 7:5 = 000) takes the unit from bits 1:0 and the head from bit 4, where 1 means the upper head. It marks a drive selected in the cycle after the write.
- R5: Once armed by a host read of the upper half, the idle timer issues a general reset TIMEOUT cycles after the last such read. The reset drops the selection. Each read restarts the count.
- R6: Opcode 4 (100) is a general reset. In the next cycle it clears the selection, the write latch, the interrupt enable and flag, and the step-rate flag.
- R7: Opcode 2 (010) raises `step_out` for exactly STEP_PULSE cycles, starting the cycle after the write. `step_inward` takes bit 0 (1 = inward) and holds it until the next step command.
- R8: `step_rate_err` sets when a step follows the previous one by fewer than SAME_GAP cycles in the same direction, or fewer than OPP_GAP cycles in the opposite direction. The step is still issued. The flag stays set until a general reset.
- R9: Opcode 3 (011) sets `write_en` two cycles after the write, when the command has ended, provided `drv_ready` is high.
- R10: `write_en` clears in the cycle after `sector_pulse` is seen, and whenever `drv_ready` is low.
- R11: With the interrupt enabled (opcode 1, bit 0 = 1), a rising edge of `sector_flag` sets `sec_irq`. Opcode 1 with bit 0 = 0 clears both the enable and the flag. A rising edge while the interrupt is disabled has no effect.
- R12: Opcodes 5 to 7, writes to offsets 2 and 3, writes to the lower half and writes with `bus_hit` low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| bus_hit | input | 1 | Host access falls inside the 1 KB window |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte |
| data_byte | input | 8 | Byte from the data path, returned at offsets 2 and 3 |
| strap | input | 2 | Two configuration strap inputs |
| sector_addr | input | 4 | Sector number under the head |
| sector_flag | input | 1 | Sector flag level from the sector separator |
| sector_pulse | input | 1 | One-cycle pulse at each sector boundary |
| trk0 | input | 1 | Drive reports track zero |
| wprot | input | 1 | Drive reports write protect |
| drv_ready | input | 1 | Drive ready |
| host_int_en | input | 1 | Host interrupt-enable state |
| xfer_flag | input | 1 | Transfer flag from the data path |
| unit_id | output | 2 | Selected drive unit |
| unit_active | output | 1 | A drive is selected |
| head_upper | output | 1 | Upper head selected |
| step_out | output | 1 | Step pulse to the drive |
| step_inward | output | 1 | Step direction, 1 = inward |
| write_en | output | 1 | Write gate to the drive |
| sec_irq | output | 1 | Sector interrupt request |
| step_rate_err | output | 1 | Sticky step-spacing violation |

## Verification
The assertions assume the following about the inputs:
- `sector_pulse` is a single-cycle strobe in the block's own clock domain.
- `sector_flag` and `drv_ready` are already synchronised levels.
- The host never issues a read and a write in the same cycle.
- The time parameters are at least 2, so the timer and the step-spacing comparisons never see a zero or negative window.

The bench follows these assumptions. It changes every input at the falling clock edge. It raises `sector_pulse` for exactly one cycle, and it issues each bus access as a one-cycle strobe on either `bus_rd` or `bus_wr`. It also shortens the timeout, step pulse and step gaps through the parameters, to values well above 2.

// File: rtl/flop_ctl_pkg.sv
// Shared types for the floppy controller register section.
// Assumes an 8-bit host data bus with opcode in bits 7:5.
package flop_ctl_pkg;

    typedef enum logic [2:0] {
        OP_SELECT = 3'd0,
        OP_IRQ    = 3'd1,
        OP_STEP   = 3'd2,
        OP_WRITE  = 3'd3,
        OP_RESET  = 3'd4,
        OP_RSV5   = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } op_e;

    // One-cycle command strobes plus the modifier bits that consumers use
    typedef struct packed {
        logic       sel;
        logic       irq;
        logic       step;
        logic       wr;
        logic       rst;
        logic [1:0] unit;
        logic       head;
        logic       arg0;
    } cmd_t;

    localparam logic [1:0] OFS_SECTOR = 2'd0;
    localparam logic [1:0] OFS_DRIVE  = 2'd1;

endpackage

// File: rtl/flop_bus_decode.sv
// Host-side decode: turns window writes into command strobes and
// selects the read byte. Pure combinational; assumes one access per cycle.
module flop_bus_decode
    import flop_ctl_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          bus_hit,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic [7:0]    sector_byte,
    input  logic [7:0]    drive_byte,
    input  logic [7:0]    data_byte,
    output logic [7:0]    bus_rdata,
    output logic          rd_touch,
    output cmd_t          cmd
);

    logic upper;
    logic wr_cmd;
    op_e  op;
    logic unused_bits;

    assign upper       = bus_hit && bus_addr[AW-1];
    assign wr_cmd      = bus_wr && upper && !bus_addr[1];
    assign op          = op_e'(bus_wdata[7:5]);
    assign rd_touch    = bus_rd && upper;
    assign unused_bits = ^{bus_wdata[3:2], bus_addr[AW-2:2]};

    // Command strobes: one per opcode, reserved opcodes produce none
    always_comb begin
        cmd      = '0;
        cmd.sel  = wr_cmd && (op == OP_SELECT);
        cmd.irq  = wr_cmd && (op == OP_IRQ);
        cmd.step = wr_cmd && (op == OP_STEP);
        cmd.wr   = wr_cmd && (op == OP_WRITE);
        cmd.rst  = wr_cmd && (op == OP_RESET);
        cmd.unit = bus_wdata[1:0];
        cmd.head = bus_wdata[4];
        cmd.arg0 = bus_wdata[0];
    end

    // Read mux: window aliasing on bits 1:0, 0xFF outside the upper half
    always_comb begin
        bus_rdata = 8'hFF;
        if (upper) begin
            case (bus_addr[1:0])
                OFS_SECTOR: bus_rdata = sector_byte;
                OFS_DRIVE:  bus_rdata = drive_byte;
                default:    bus_rdata = data_byte;
            endcase
        end
    end

endmodule

// File: rtl/flop_idle_timer.sv
// Retriggerable idle timer: armed and restarted by each host read,
// pulses expire for one cycle after TIMEOUT idle cycles, then disarms.
// Assumes TIMEOUT >= 2.
module flop_idle_timer #(
    parameter int TIMEOUT = 500_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic touch,
    output logic expire
);

    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    logic [TW-1:0] cnt;
    logic          armed;

    assign expire = armed && (cnt == LAST) && !touch;

    // Count idle cycles while armed; a read restarts from zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (touch) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (expire) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (armed) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_single_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    p_touch_defers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> !expire);

endmodule

// File: rtl/flop_stepper.sv
// Head stepper: fixed-length step pulse, latched direction, and a sticky
// flag for steps spaced closer than the drive's settle windows.
// Assumes SAME_GAP and OPP_GAP >= 2.
module flop_stepper #(
    parameter int STEP_PULSE = 63,
    parameter int SAME_GAP   = 3_750_000,
    parameter int OPP_GAP    = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic go,
    input  logic dir_req,
    output logic step_out,
    output logic step_inward,
    output logic rate_err
);

    localparam int GMAX = (SAME_GAP > OPP_GAP) ? SAME_GAP : OPP_GAP;
    localparam int PW   = $clog2(STEP_PULSE + 1);
    localparam int GW   = $clog2(GMAX + 1);
    localparam logic [PW-1:0] PLOAD    = PW'(STEP_PULSE);
    localparam logic [GW-1:0] GSAT     = GW'(GMAX);
    localparam logic [GW-1:0] SAME_LIM = GW'(SAME_GAP - 1);
    localparam logic [GW-1:0] OPP_LIM  = GW'(OPP_GAP - 1);

    logic [PW-1:0] pcnt;
    logic [GW-1:0] gap;
    logic          have_prev;
    logic          too_close;

    assign step_out  = (pcnt != '0);
    assign too_close = have_prev &&
                       ((dir_req == step_inward) ? (gap < SAME_LIM) : (gap < OPP_LIM));

    // Pulse timer, direction latch, spacing counter and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt        <= '0;
            gap         <= '0;
            have_prev   <= 1'b0;
            step_inward <= 1'b0;
            rate_err    <= 1'b0;
        end else begin
            if (go) begin
                pcnt        <= PLOAD;
                step_inward <= dir_req;
                gap         <= '0;
                have_prev   <= 1'b1;
                if (too_close) rate_err <= 1'b1;
            end else begin
                if (pcnt != '0) pcnt <= pcnt - 1'b1;
                if (gap != GSAT) gap <= gap + 1'b1;
            end
            if (clr) begin
                rate_err  <= 1'b0;
                have_prev <= 1'b0;
            end
        end
    end

    p_pulse_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> step_out);

    p_dir_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(step_inward));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_err && !clr) |=> rate_err);

endmodule

// File: rtl/flop_drive_state.sv
// Drive selection, write-enable latch and sector interrupt state.
// Assumes sector_pulse is one cycle wide and sector_flag is synchronous.
module flop_drive_state
    import flop_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  cmd_t       cmd,
    input  logic       drv_ready,
    input  logic       sector_pulse,
    input  logic       sector_flag,
    output logic [1:0] unit_id,
    output logic       head_upper,
    output logic       unit_active,
    output logic       write_en,
    output logic       sec_irq
);

    logic wr_pend;
    logic irq_en;
    logic sf_q;
    logic sf_rise;

    assign sf_rise = sector_flag && !sf_q;

    // Drive and head selection register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            unit_id     <= '0;
            head_upper  <= 1'b0;
            unit_active <= 1'b0;
        end else if (cmd.sel) begin
            unit_id     <= cmd.unit;
            head_upper  <= cmd.head;
            unit_active <= 1'b1;
        end
    end

    // Write latch: sets once the command has ended, closes on sector or not-ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend  <= 1'b0;
            write_en <= 1'b0;
        end else begin
            wr_pend <= cmd.wr && !clr;
            if (clr || sector_pulse || !drv_ready) write_en <= 1'b0;
            else if (wr_pend)                      write_en <= 1'b1;
        end
    end

    // Sector interrupt enable and flag, set on sector-flag rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en  <= 1'b0;
            sec_irq <= 1'b0;
            sf_q    <= 1'b0;
        end else begin
            sf_q <= sector_flag;
            if (clr || (cmd.irq && !cmd.arg0)) begin
                irq_en  <= 1'b0;
                sec_irq <= 1'b0;
            end else begin
                if (cmd.irq)           irq_en  <= 1'b1;
                if (sf_rise && irq_en) sec_irq <= 1'b1;
            end
        end
    end

    p_wen_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_ready |=> !write_en);

    p_wen_sector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sector_pulse |=> !write_en);

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sec_irq |-> irq_en);

    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!unit_active && !write_en && !sec_irq && !irq_en));

endmodule

// File: rtl/flop_ctl_regs.sv
// Top of the floppy controller register section: window decode, idle
// timer, stepper and drive state. General reset = reset command or
// timer expiry; power-on clear is the synchronous rst_n.
module flop_ctl_regs
    import flop_ctl_pkg::*;
#(
    parameter int WINDOW_BYTES = 1024,
    parameter int TIMEOUT      = 500_000_000,
    parameter int STEP_PULSE   = 63,
    parameter int SAME_GAP     = 3_750_000,
    parameter int OPP_GAP      = 5_000_000,
    localparam int AW          = $clog2(WINDOW_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_hit,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    data_byte,
    input  logic [1:0]    strap,
    input  logic [3:0]    sector_addr,
    input  logic          sector_flag,
    input  logic          sector_pulse,
    input  logic          trk0,
    input  logic          wprot,
    input  logic          drv_ready,
    input  logic          host_int_en,
    input  logic          xfer_flag,
    output logic [1:0]    unit_id,
    output logic          unit_active,
    output logic          head_upper,
    output logic          step_out,
    output logic          step_inward,
    output logic          write_en,
    output logic          sec_irq,
    output logic          step_rate_err
);

    cmd_t       cmd;
    logic       rd_touch;
    logic       expire;
    logic       gen_rst;
    logic [7:0] sector_byte;
    logic [7:0] drive_byte;

    assign gen_rst     = cmd.rst || expire;
    assign sector_byte = {sector_flag, sec_irq, strap, sector_addr};
    assign drive_byte  = {xfer_flag, host_int_en, drv_ready, wprot, trk0,
                          !unit_active, unit_id};

    flop_bus_decode #(.AW(AW)) u_decode (
        .bus_hit     (bus_hit),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .sector_byte (sector_byte),
        .drive_byte  (drive_byte),
        .data_byte   (data_byte),
        .bus_rdata   (bus_rdata),
        .rd_touch    (rd_touch),
        .cmd         (cmd)
    );

    flop_idle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .touch  (rd_touch),
        .expire (expire)
    );

    flop_stepper #(
        .STEP_PULSE (STEP_PULSE),
        .SAME_GAP   (SAME_GAP),
        .OPP_GAP    (OPP_GAP)
    ) u_stepper (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (gen_rst),
        .go          (cmd.step),
        .dir_req     (cmd.arg0),
        .step_out    (step_out),
        .step_inward (step_inward),
        .rate_err    (step_rate_err)
    );

    flop_drive_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (gen_rst),
        .cmd          (cmd),
        .drv_ready    (drv_ready),
        .sector_pulse (sector_pulse),
        .sector_flag  (sector_flag),
        .unit_id      (unit_id),
        .head_upper   (head_upper),
        .unit_active  (unit_active),
        .write_en     (write_en),
        .sec_irq      (sec_irq)
    );

    p_timeout_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !unit_active);

    p_one_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd.sel, cmd.irq, cmd.step, cmd.wr, cmd.rst}));

    p_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.sel && !expire) |=> unit_active);

endmodule

// File: tb/flop_ctl_regs_bench.sv
// Self-checking bench for flop_ctl_regs: table-driven command checks
// followed by directed tests for timing and corner cases.
module flop_ctl_regs_bench;

    localparam int T_OUT  = 60;
    localparam int T_STEP = 4;
    localparam int G_SAME = 20;
    localparam int G_OPP  = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_hit = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] data_byte = 8'h5A;
    logic [1:0] strap = 2'b10;
    logic [3:0] sector_addr = 4'h9;
    logic       sector_flag = 1'b0, sector_pulse = 1'b0;
    logic       trk0 = 1'b1, wprot = 1'b0, drv_ready = 1'b1;
    logic       host_int_en = 1'b0, xfer_flag = 1'b1;
    logic [1:0] unit_id;
    logic       unit_active, head_upper, step_out, step_inward;
    logic       write_en, sec_irq, step_rate_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    flop_ctl_regs #(
        .TIMEOUT    (T_OUT),
        .STEP_PULSE (T_STEP),
        .SAME_GAP   (G_SAME),
        .OPP_GAP    (G_OPP)
    ) u_flop_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_hit(bus_hit), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .data_byte(data_byte), .strap(strap),
        .sector_addr(sector_addr), .sector_flag(sector_flag),
        .sector_pulse(sector_pulse), .trk0(trk0), .wprot(wprot),
        .drv_ready(drv_ready), .host_int_en(host_int_en),
        .xfer_flag(xfer_flag), .unit_id(unit_id), .unit_active(unit_active),
        .head_upper(head_upper), .step_out(step_out),
        .step_inward(step_inward), .write_en(write_en), .sec_irq(sec_irq),
        .step_rate_err(step_rate_err)
    );

    // {write?, addr, data, expected drive status byte}
    localparam int NV = 10;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 10'h000, 8'h00, 8'hAC},
        {1'b1, 10'h200, 8'h02, 8'hAA},
        {1'b1, 10'h201, 8'h13, 8'hAB},
        {1'b1, 10'h202, 8'h00, 8'hAB},
        {1'b1, 10'h3FD, 8'h01, 8'hA9},
        {1'b1, 10'h200, 8'hA0, 8'hA9},
        {1'b1, 10'h001, 8'h00, 8'hA9},
        {1'b1, 10'h200, 8'h80, 8'hAC},
        {1'b1, 10'h200, 8'hE3, 8'hAC},
        {1'b1, 10'h200, 8'h03, 8'hAB}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_hit = 1'b1; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_hit = 1'b1; bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic hit, input logic [9:0] a, output logic [7:0] d);
        bus_hit = hit; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R3, R6 defaults)
        peek(1'b1, 10'h201, rd);
        chk("R3 reset drive status", rd, 8'hAC);
        chk("R7 reset step_out", step_out, 0);
        chk("R9 reset write_en", write_en, 0);
        chk("R11 reset sec_irq", sec_irq, 0);

        // R1 window decode
        peek(1'b0, 10'h201, rd);  chk("R1 outside window", rd, 8'hFF);
        peek(1'b1, 10'h005, rd);  chk("R1 lower half", rd, 8'hFF);
        peek(1'b1, 10'h202, rd);  chk("R1 offset 2 data", rd, 8'h5A);
        peek(1'b1, 10'h3FF, rd);  chk("R1 alias offset 3 data", rd, 8'h5A);

        // R2 sector status byte
        sector_flag = 1'b1;
        @(negedge clk);
        peek(1'b1, 10'h3FC, rd);
        chk("R2 sector byte", rd, 8'hA9);
        sector_flag = 1'b0;

        // R4 / R12 table of commands
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][26]) bus_write(VEC[i][25:16], VEC[i][15:8]);
            peek(1'b1, 10'h201, rd);
            chk($sformatf("R4/R12 table %0d", i), rd, VEC[i][7:0]);
        end
        bus_write(10'h200, 8'h12);
        chk("R4 head upper", head_upper, 1);
        chk("R4 unit id", unit_id, 2);
        @(negedge clk); bus_hit = 1'b0; bus_addr = 10'h200; bus_wdata = 8'h80; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        chk("R12 write with hit low ignored", unit_active, 1);

        // R9 / R10 write latch
        bus_write(10'h200, 8'h60);
        chk("R9 write_en not yet", write_en, 0);
        @(negedge clk);
        chk("R9 write_en set", write_en, 1);
        sector_pulse = 1'b1; @(negedge clk); sector_pulse = 1'b0;
        chk("R10 sector pulse clears", write_en, 0);
        bus_write(10'h200, 8'h60); @(negedge clk);
        chk("R9 set again", write_en, 1);
        drv_ready = 1'b0; @(negedge clk);
        chk("R10 not ready clears", write_en, 0);
        bus_write(10'h200, 8'h60); @(negedge clk);
        chk("R9 blocked when not ready", write_en, 0);
        drv_ready = 1'b1; @(negedge clk);
        chk("R9 stays clear after ready returns", write_en, 0);

        // R11 sector interrupt
        bus_write(10'h200, 8'h21);
        sector_flag = 1'b1; @(negedge clk);
        peek(1'b1, 10'h200, rd);
        chk("R11 irq set on rise", rd[6], 1);
        chk("R11 irq port", sec_irq, 1);
        bus_write(10'h200, 8'h20);
        chk("R11 disable clears", sec_irq, 0);
        sector_flag = 1'b0; @(negedge clk);
        sector_flag = 1'b1; @(negedge clk);
        chk("R11 no set while disabled", sec_irq, 0);
        sector_flag = 1'b0;

        // R6 reset command clears everything
        bus_write(10'h200, 8'h01);
        bus_write(10'h200, 8'h21);
        sector_flag = 1'b1; @(negedge clk); sector_flag = 1'b0;
        bus_write(10'h200, 8'h60); @(negedge clk);
        bus_write(10'h200, 8'h80);
        chk("R6 unit cleared", unit_active, 0);
        chk("R6 write_en cleared", write_en, 0);
        chk("R6 irq cleared", sec_irq, 0);

        // R7 step pulse and direction
        bus_write(10'h200, 8'h41);
        chk("R7 pulse high", step_out, 1);
        chk("R7 dir inward", step_inward, 1);
        repeat (T_STEP - 1) @(negedge clk);
        chk("R7 pulse still high", step_out, 1);
        @(negedge clk);
        chk("R7 pulse ended", step_out, 0);
        chk("R7 dir held", step_inward, 1);

        // R8 step spacing
        repeat (25) @(negedge clk);
        bus_write(10'h200, 8'h41);
        chk("R8 spaced same-dir ok", step_rate_err, 0);
        bus_write(10'h200, 8'h40);
        chk("R8 close opposite-dir flagged", step_rate_err, 1);
        chk("R7 dir outward", step_inward, 0);
        chk("R8 step still issued", step_out, 1);
        repeat (40) @(negedge clk);
        chk("R8 sticky", step_rate_err, 1);
        bus_write(10'h200, 8'h80);
        chk("R8 cleared by reset", step_rate_err, 0);
        bus_write(10'h200, 8'h41);
        repeat (5) @(negedge clk);
        bus_write(10'h200, 8'h41);
        chk("R8 close same-dir flagged", step_rate_err, 1);
        bus_write(10'h200, 8'h80);

        // R5 idle timer
        bus_write(10'h200, 8'h01);
        bus_read(10'h201, rd);
        repeat (T_OUT - 1) @(negedge clk);
        chk("R5 active before timeout", unit_active, 1);
        @(negedge clk);
        chk("R5 dropped at timeout", unit_active, 0);
        bus_write(10'h200, 8'h02);
        bus_read(10'h200, rd);
        repeat (40) @(negedge clk);
        bus_read(10'h202, rd);
        repeat (40) @(negedge clk);
        chk("R5 retrigger keeps select", unit_active, 1);
        repeat (20) @(negedge clk);
        chk("R5 expires after retrigger", unit_active, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule